// File: doc/BRIEF.md
# Adaptive Loop-Gain Mode Controller

This block is the loop-gain manager of a digitally controlled linear regulator. The regulator's comparators produce one sample packet per regulation period. The packet holds two magnitude flags (first-phase and later-phase error over threshold) and a vector of direction bits, one per sampling phase. From each packet the controller chooses which thermometer array steps (coarse or fine) and how far the next integration step reaches (x1, x4 or x16). It also chooses whether the multi-phase sampling stays switched on.

A large first-phase error puts the block in coarse tuning. If a later phase confirms the error, the block accelerates, and the step size then follows how many phases agree in direction. Repeated mixed-direction periods bring the gain back down, first to unit steps and then to a single-phase steady state. Saturation flags from the ends of the coarse thermometer register block further steps into a full or empty array and pass control to the fine array.

Top module: `loop_gain_ctrl`

## Requirements
- R1: After reset the block is in steady state: mode_o=0, mult_o=00 (x1), mp_sw_o=00 (single-phase sampling).
- R2: A sample (samp_vld=1) with big_err[0]=1 taken in steady state or in either fine state moves the block to coarse unit-step: mode_o=1, mult_o=00, mp_sw_o=11.
- R3: In coarse unit-step, a sample with big_err[1]=1 (and no saturation) enters coarse acceleration. In both accelerated states the multiplier comes from the agreement count, which is the number of err_vec bits equal to err_vec[0]. A count of 4 gives mult_o=10 (x16), 2 or 3 gives 01 (x4), and below 2 gives 00 (x1). Code 11 never appears.
- R4: A period is mixed when fewer than all four bits agree, or when err_vec[0] differs from the previous sample's err_vec[0]. An accelerated state returns to its unit-step state, with mult_o=00, on the second consecutive mixed period. A non-mixed period restarts the count.
- R5: In coarse unit-step, a sample with big_err=00 and no saturation moves the block to fine unit-step: mode_o=0, mult_o=00, mp_sw_o=01.
- R6: In fine unit-step, a sample with big_err[0]=0 and all four bits agreeing enters fine acceleration (mode_o=0, mp_sw_o=01, multiplier per R3).
- R7: In fine unit-step, two consecutive mixed periods return the block to steady state (mp_sw_o=00, mult_o=00). Whenever mp_sw_o=00, mode_o=0 and mult_o=00.
- R8: In steady state, a sample with big_err[0]=0 and fewer than four agreeing bits leaves all outputs unchanged. Four agreeing bits move the block to fine unit-step.
- R9: During samp_vld, step_up_o equals err_vec[0] (1 = raise). crs_step_en_o is 1 when mode_o=1 and fne_step_en_o is 1 when mode_o=0. Both are 0 without samp_vld.
- R10: A coarse step is blocked (crs_step_en_o=0) when crs_full=1 with err_vec[0]=1, or crs_empty=1 with err_vec[0]=0. Such a blocked sample taken in a coarse state moves the block to fine unit-step. A coarse step in the direction away from the saturated end is still allowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_vld | input | 1 | One-cycle strobe: sample packet valid |
| big_err | input | 2 | [0] first phase over threshold, [1] later phase over threshold |
| err_vec | input | NPH (4) | Direction bit per sampling phase, 1 = output below reference |
| crs_full | input | 1 | Top bit of coarse thermometer register set |
| crs_empty | input | 1 | Bottom bit of coarse thermometer register clear |
| mode_o | output | 1 | 1 = coarse tuning, 0 = fine tuning |
| mult_o | output | 2 | Step multiplier code: 00 x1, 01 x4, 10 x16 |
| mp_sw_o | output | 2 | Sampling control: 00 single-phase, 01 multi-phase fine, 11 multi-phase coarse |
| step_up_o | output | 1 | Step direction for this sample |
| crs_step_en_o | output | 1 | Coarse array steps this cycle |
| fne_step_en_o | output | 1 | Fine array steps this cycle |

## Verification
The hardest situations to reach are the two exits that need a history. One is leaving an accelerated state on exactly the second consecutive mixed period. The other is the coarse-to-fine handover under saturation. For the first, the stimulus first walks the block through large-error packets into acceleration. It then interleaves mixed and fully agreeing packets, so that a single mixed period is seen to restart rather than exit, and a direction reversal with full agreement is seen to count as mixed. For the second, the coarse register is held full while packets of both directions arrive: a step away from the full end must still be taken, and only a step into the full end is refused and hands over to the fine array. The empty end is then exercised from coarse acceleration.

// File: rtl/lgc_pkg.sv
// Shared types for the loop-gain controller.
// Assumes: multiplier codes are decoded by the thermometer shift logic downstream.
package lgc_pkg;
    typedef enum logic [2:0] {
        ST_STEADY   = 3'd0,
        ST_CRS_UNIT = 3'd1,
        ST_CRS_DYN  = 3'd2,
        ST_FNE_UNIT = 3'd3,
        ST_FNE_DYN  = 3'd4
    } lgc_state_e;

    typedef enum logic [1:0] {
        MULT_X1  = 2'b00,
        MULT_X4  = 2'b01,
        MULT_X16 = 2'b10
    } lgc_mult_e;

    localparam logic [1:0] MPSW_OFF    = 2'b00;
    localparam logic [1:0] MPSW_FINE   = 2'b01;
    localparam logic [1:0] MPSW_COARSE = 2'b11;
endpackage

// File: rtl/lgc_err_sum.sv
// Error trend summary: agreement count of phase directions with the first
// phase, and a mixed-period flag (partial agreement or direction reversal).
// Assumes: err_vec is stable while samp_vld is high.
module lgc_err_sum #(
    parameter int NPH = 4,
    localparam int CW = $clog2(NPH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           samp_vld,
    input  logic [NPH-1:0] err_vec,
    output logic           dir,
    output logic [CW-1:0]  agree,
    output logic           all_agree,
    output logic           mixed
);
    logic prev_dir_q;

    // Count phases whose direction matches the first phase.
    always_comb begin
        agree = '0;
        for (int i = 0; i < NPH; i++) begin
            agree = agree + CW'(err_vec[i] == err_vec[0]);
        end
    end

    assign dir       = err_vec[0];
    assign all_agree = (agree == CW'(NPH));
    assign mixed     = !all_agree || (dir != prev_dir_q);

    // Remember the direction of the last accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)        prev_dir_q <= 1'b0;
        else if (samp_vld) prev_dir_q <= dir;
    end
endmodule

// File: rtl/lgc_ovf_mon.sv
// Saturation monitor for the coarse thermometer register: flags a step that
// would push past the full or empty end.
// Assumes: full and empty are never both set.
module lgc_ovf_mon (
    input  logic dir,
    input  logic crs_full,
    input  logic crs_empty,
    output logic sat
);
    // A step is saturating when it points into the end already reached.
    always_comb sat = (dir && crs_full) || (!dir && crs_empty);
endmodule

// File: rtl/lgc_fsm.sv
// Mode state machine: selects coarse/fine tuning, acceleration and steady
// state, and the step multiplier, once per accepted sample.
// Assumes: all inputs are qualified by samp_vld.
module lgc_fsm
    import lgc_pkg::*;
#(
    parameter int NPH      = 4,
    parameter int EXIT_CNT = 2,
    localparam int CW = $clog2(NPH + 1),
    localparam int XW = $clog2(EXIT_CNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          samp_vld,
    input  logic [1:0]    big_err,
    input  logic [CW-1:0] agree,
    input  logic          all_agree,
    input  logic          mixed,
    input  logic          sat,
    output lgc_state_e    state_o,
    output lgc_mult_e     mult_o
);
    lgc_state_e state_q, state_d;
    lgc_mult_e  mult_q, mult_d;
    logic [XW-1:0] mix_cnt_q;
    logic          exit_hit;

    assign exit_hit = mixed && (mix_cnt_q == XW'(EXIT_CNT - 1));

    // Next-state choice from magnitude flags, trend and saturation.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STEADY: begin
                if (big_err[0])     state_d = ST_CRS_UNIT;
                else if (all_agree) state_d = ST_FNE_UNIT;
            end
            ST_CRS_UNIT: begin
                if (sat)             state_d = ST_FNE_UNIT;
                else if (big_err[1]) state_d = ST_CRS_DYN;
                else if (!big_err[0]) state_d = ST_FNE_UNIT;
            end
            ST_CRS_DYN: begin
                if (sat)           state_d = ST_FNE_UNIT;
                else if (exit_hit) state_d = ST_CRS_UNIT;
            end
            ST_FNE_UNIT: begin
                if (big_err[0])     state_d = ST_CRS_UNIT;
                else if (all_agree) state_d = ST_FNE_DYN;
                else if (exit_hit)  state_d = ST_STEADY;
            end
            ST_FNE_DYN: begin
                if (big_err[0])    state_d = ST_CRS_UNIT;
                else if (exit_hit) state_d = ST_FNE_UNIT;
            end
            default: state_d = ST_STEADY;
        endcase
    end

    // Multiplier for the coming period: trend-based only when accelerated.
    always_comb begin
        mult_d = MULT_X1;
        if (state_d == ST_CRS_DYN || state_d == ST_FNE_DYN) begin
            if (agree == CW'(NPH))          mult_d = MULT_X16;
            else if (agree >= CW'(NPH / 2)) mult_d = MULT_X4;
        end
    end

    // State, multiplier and mixed-period counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_STEADY;
            mult_q    <= MULT_X1;
            mix_cnt_q <= '0;
        end else if (samp_vld) begin
            state_q <= state_d;
            mult_q  <= mult_d;
            if (state_d != state_q)          mix_cnt_q <= '0;
            else if (!mixed)                 mix_cnt_q <= '0;
            else if (mix_cnt_q != XW'(EXIT_CNT)) mix_cnt_q <= mix_cnt_q + 1'b1;
        end
    end

    assign state_o = state_q;
    assign mult_o  = mult_q;

    AST_BIG_TO_COARSE: assert property (@(posedge clk) disable iff (!rst_n)
        samp_vld && big_err[0] && (state_q == ST_STEADY || state_q == ST_FNE_UNIT || state_q == ST_FNE_DYN)
        |=> state_q == ST_CRS_UNIT); // R2
    AST_DYN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        samp_vld && state_q == ST_CRS_UNIT && big_err[1] && !sat |=> state_q == ST_CRS_DYN); // R3
    AST_MULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mult_q != 2'b11); // R3
    AST_NO_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_vld |=> $stable(state_q) && $stable(mult_q)); // R8
endmodule

// File: rtl/loop_gain_ctrl.sv
// Adaptive loop-gain mode controller top: joins the trend summary, the
// saturation monitor and the mode machine, and drives the step enables.
// Assumes: one samp_vld strobe per regulation period.
module loop_gain_ctrl
    import lgc_pkg::*;
#(
    parameter int NPH      = 4,
    parameter int EXIT_CNT = 2,
    localparam int CW = $clog2(NPH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           samp_vld,
    input  logic [1:0]     big_err,
    input  logic [NPH-1:0] err_vec,
    input  logic           crs_full,
    input  logic           crs_empty,
    output logic           mode_o,
    output logic [1:0]     mult_o,
    output logic [1:0]     mp_sw_o,
    output logic           step_up_o,
    output logic           crs_step_en_o,
    output logic           fne_step_en_o
);
    logic          dir, all_agree, mixed, sat;
    logic [CW-1:0] agree;
    lgc_state_e    state;
    lgc_mult_e     mult;

    lgc_err_sum #(.NPH(NPH)) u_sum (
        .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .err_vec(err_vec),
        .dir(dir), .agree(agree), .all_agree(all_agree), .mixed(mixed)
    );

    lgc_ovf_mon u_ovf (
        .dir(dir), .crs_full(crs_full), .crs_empty(crs_empty), .sat(sat)
    );

    lgc_fsm #(.NPH(NPH), .EXIT_CNT(EXIT_CNT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .big_err(big_err),
        .agree(agree), .all_agree(all_agree), .mixed(mixed), .sat(sat),
        .state_o(state), .mult_o(mult)
    );

    // Mode and sampling control decoded from the state.
    always_comb begin
        mode_o  = (state == ST_CRS_UNIT) || (state == ST_CRS_DYN);
        mult_o  = mult;
        if (state == ST_STEADY) mp_sw_o = MPSW_OFF;
        else if (mode_o)        mp_sw_o = MPSW_COARSE;
        else                    mp_sw_o = MPSW_FINE;
    end

    // Step enables for the arrays, with saturation blocking on coarse.
    always_comb begin
        step_up_o     = dir;
        crs_step_en_o = samp_vld && mode_o && !sat;
        fne_step_en_o = samp_vld && !mode_o;
    end

    AST_SAT_BLOCK_UP: assert property (@(posedge clk) disable iff (!rst_n)
        samp_vld && crs_full && err_vec[0] |-> !crs_step_en_o); // R10
    AST_SAT_BLOCK_DN: assert property (@(posedge clk) disable iff (!rst_n)
        samp_vld && crs_empty && !err_vec[0] |-> !crs_step_en_o); // R10
    AST_ONE_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        !(crs_step_en_o && fne_step_en_o)); // R9
    AST_STEADY_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
        mp_sw_o == MPSW_OFF |-> (mult_o == MULT_X1 && !mode_o)); // R7
endmodule

// File: tb/loop_gain_ctrl_tb_top.sv
`timescale 1ns/1ps
module loop_gain_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       samp_vld = 1'b0;
    logic [1:0] big_err = 2'b00;
    logic [3:0] err_vec = 4'b0000;
    logic       crs_full = 1'b0, crs_empty = 1'b0;
    logic       mode_o, step_up_o, crs_step_en_o, fne_step_en_o;
    logic [1:0] mult_o, mp_sw_o;

    int n_chk = 0;
    int n_err = 0;
    logic [4:0] exp_q[$];
    string      req_q[$];

    always #2 clk = ~clk;

    loop_gain_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .samp_vld(samp_vld), .big_err(big_err),
        .err_vec(err_vec), .crs_full(crs_full), .crs_empty(crs_empty),
        .mode_o(mode_o), .mult_o(mult_o), .mp_sw_o(mp_sw_o), .step_up_o(step_up_o),
        .crs_step_en_o(crs_step_en_o), .fne_step_en_o(fne_step_en_o)
    );

    task automatic check(input bit ok, input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Driver: apply one sample packet, check enables, queue expected state.
    task automatic samp(input logic [1:0] big, input logic [3:0] vec, input logic full, input logic empty,
                        input logic em, input logic [1:0] emult, input logic [1:0] esw,
                        input logic ecrs, input logic efne, input string req);
        @(negedge clk);
        big_err = big; err_vec = vec; crs_full = full; crs_empty = empty; samp_vld = 1'b1;
        #1;
        check({step_up_o, crs_step_en_o, fne_step_en_o} == {vec[0], ecrs, efne}, {req, " R9 enables"},
              {2'b00, step_up_o, crs_step_en_o, fne_step_en_o}, {2'b00, vec[0], ecrs, efne});
        @(posedge clk);
        @(negedge clk);
        samp_vld = 1'b0;
        exp_q.push_back({em, emult, esw});
        req_q.push_back(req);
    endtask

    // Monitor: compare outputs after each update against the queue.
    always @(posedge clk) begin
        #1;
        while (exp_q.size() > 0) begin
            logic [4:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check({mode_o, mult_o, mp_sw_o} == e, r, {mode_o, mult_o, mp_sw_o}, e);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check({mode_o, mult_o, mp_sw_o} == 5'b0_00_00, "R1 reset", {mode_o, mult_o, mp_sw_o}, 5'b0_00_00);
        check({crs_step_en_o, fne_step_en_o} == 2'b00, "R9 idle", {3'b000, crs_step_en_o, fne_step_en_o}, 5'b0);
        //    big    vec      f  e   mode mult   sw   crs fne
        samp(2'b00, 4'b0101, 0, 0, 0, 2'b00, 2'b00, 0, 1, "R8 steady partial");
        samp(2'b01, 4'b1111, 0, 0, 1, 2'b00, 2'b11, 0, 1, "R2 coarse entry");
        samp(2'b11, 4'b1111, 0, 0, 1, 2'b10, 2'b11, 1, 0, "R3 dyn x16");
        samp(2'b11, 4'b0111, 0, 0, 1, 2'b01, 2'b11, 1, 0, "R3 dyn x4 mixed1");
        samp(2'b11, 4'b1111, 0, 0, 1, 2'b10, 2'b11, 1, 0, "R4 count restart");
        samp(2'b11, 4'b0011, 0, 0, 1, 2'b01, 2'b11, 1, 0, "R4 mixed1");
        samp(2'b11, 4'b0001, 0, 0, 1, 2'b00, 2'b11, 1, 0, "R4 exit to unit");
        samp(2'b00, 4'b1111, 0, 0, 0, 2'b00, 2'b01, 1, 0, "R5 coarse settled");
        samp(2'b00, 4'b1111, 0, 0, 0, 2'b10, 2'b01, 0, 1, "R6 fine dyn");
        samp(2'b00, 4'b0000, 0, 0, 0, 2'b10, 2'b01, 0, 1, "R4 reversal mixed");
        samp(2'b00, 4'b0110, 0, 0, 0, 2'b00, 2'b01, 0, 1, "R4 fine exit");
        samp(2'b00, 4'b1010, 0, 0, 0, 2'b00, 2'b01, 0, 1, "R7 mixed1");
        samp(2'b00, 4'b0101, 0, 0, 0, 2'b00, 2'b00, 0, 1, "R7 to steady");
        samp(2'b00, 4'b1111, 0, 0, 0, 2'b00, 2'b01, 0, 1, "R8 steady wake");
        samp(2'b01, 4'b1111, 0, 0, 1, 2'b00, 2'b11, 0, 1, "R2 from fine");
        samp(2'b01, 4'b0000, 1, 0, 1, 2'b00, 2'b11, 1, 0, "R10 away from full");
        samp(2'b01, 4'b1111, 1, 0, 0, 2'b00, 2'b01, 0, 0, "R10 full handover");
        samp(2'b00, 4'b1111, 0, 0, 0, 2'b10, 2'b01, 0, 1, "R6 fine dyn again");
        samp(2'b01, 4'b1111, 0, 0, 1, 2'b00, 2'b11, 0, 1, "R6 big to coarse");
        samp(2'b11, 4'b1111, 0, 0, 1, 2'b10, 2'b11, 1, 0, "R3 dyn again");
        samp(2'b11, 4'b0000, 0, 1, 0, 2'b00, 2'b01, 0, 0, "R10 empty handover");
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check({mode_o, mult_o, mp_sw_o} == 5'b0_00_00, "R1 reset again", {mode_o, mult_o, mp_sw_o}, 5'b0_00_00);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule